// File: doc/BRIEF.md
# Execution-Cycle Timing Generator

This block tracks which execution cycle an 8-bit processor core is in. It drives the time codes that qualify instruction decode. Six codes are active low: an end-of-instruction cycle (T0), a post-T0 fetch marker (T+) and the stepping cycles T2 through T5. One fetch flag, T1, is active high and is copied to a SYNC output.

The codes are not strictly one-hot. T0 can be active together with T2 for two-cycle opcodes. T0 and T+ are active together while a sensed reset is held. A branch that skips the end cycle gives a bare T1 with T+ inactive. Cycle extension chains outside this block, such as those for interrupt entry or read-modify-write, end an instruction only through the end-of-instruction request input.

The number of stepping cycles is the parameter `N_STEP`. With the default of 4, `tstep_n[0]` is T2 and `tstep_n[3]` is T5.

Top module: `tcg_timing_gen`

## Requirements
- R1: With no request, the stepping codes advance one per cycle: T2, T3, and so on up to the last. After the last stepping code, every code is inactive, and the block stays in that idle state for as long as no request or reset arrives.
- R2: An end request (`end_req`) raised in any stepping or idle cycle makes the next cycle T0 alone.
- R3: Without reset, a cycle with T0 active is followed by a cycle with T+ and T1 both active and no stepping code active.
- R4: From a T1 cycle with `two_cyc` high, the next cycle has T0 and T2 active together. With `two_cyc` low, the next cycle has T2 alone.
- R5: `br_bypass` during T2 or T3 makes the next cycle T1 with T+ inactive. T+ is only ever active in a cycle that follows a cycle with T0 active.
- R6: `rst_sense` high in a cycle forces the next cycle to T0 and clears every stepping code and T1.
- R7: `rst_sense` high during a cycle with T0 active gives T0 together with T+ in the next cycle. This state repeats while `rst_sense` stays high. Once `rst_sense` falls, the next cycle is T+ with T1.
- R8: An end request during a T1 cycle does not change that cycle. The cycle after it becomes T0 alone instead of T2, which produces an extra T0 cycle followed by an extra T+/T1 cycle.
- R9: `t0_n`, `tplus_n` and `tstep_n` are low when their code is active. `t1` and `sync` are high in fetch cycles and equal each other.
- R10: After `rst_n` is released, the first cycle is T0 alone. The requests are applied in priority order: reset first, then T0, then T1, then bypass, then end request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-up reset, active low, asynchronous |
| two_cyc | input | 1 | Predecode flag: the fetched opcode is a two-cycle opcode |
| end_req | input | 1 | Request for T0 in the next cycle |
| br_bypass | input | 1 | Branch ends without a T0 cycle |
| rst_sense | input | 1 | Reset has been sensed in this cycle |
| t0_n | output | 1 | T0, active low |
| tplus_n | output | 1 | T+, active low |
| tstep_n | output | N_STEP | T2 through T(N_STEP+1), active low, bit 0 is T2 |
| t1 | output | 1 | Fetch cycle, active high |
| sync | output | 1 | Opcode fetch marker, same value as t1 |

## Verification
The bench targets the multi-hot states:
- **Two-cycle start:** a design that stepped one-hot would show T2 without T0 after a two-cycle fetch.
- **Held reset:** a design that ignored T0 in the reset path would never produce the T0-with-T+ hold state.
- **Bypass exit:** a design that set T+ on every fetch would show T+ after a bypassed branch.
- **End request during fetch:** a request that landed during T1 and was dropped or acted on early would lose the extra T0 and T+/T1 pair.

The bench also runs the no-request path into the idle state, and checks that the idle state is left only by a request or by reset.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
   // Flags outside the stepping chain, all active high inside the block
   typedef struct packed {
      logic t0;
      logic tplus;
      logic t1;
   } tcg_flags_t;

   localparam tcg_flags_t TCG_FLAGS_RESET = '{t0: 1'b1, tplus: 1'b0, t1: 1'b0};
endpackage

// File: rtl/tcg_next.sv
module tcg_next
   import tcg_pkg::*;
#(
   parameter int N_STEP = 4
) (
   input  tcg_flags_t        cur_f,
   input  logic [N_STEP-1:0] cur_s,
   input  logic              two_cyc,
   input  logic              end_req,
   input  logic              br_bypass,
   input  logic              rst_sense,
   output tcg_flags_t        nxt_f,
   output logic [N_STEP-1:0] nxt_s
);
   localparam int BYP_BITS = (N_STEP < 2) ? N_STEP : 2;

   logic [N_STEP-1:0] shifted;
   logic              in_byp_window;

   // Stepping chain: each code hands over to the next, the last one drops out
   assign shifted[0] = 1'b0;
   for (genvar gi = 1; gi < N_STEP; gi++) begin : g_shift
      assign shifted[gi] = cur_s[gi-1];
   end

   // Bypass is honoured in T2 and T3 only
   assign in_byp_window = |cur_s[BYP_BITS-1:0];

   always_comb begin
      nxt_f = '0;
      nxt_s = '0;
      if (rst_sense) begin
         nxt_f.t0    = 1'b1;
         nxt_f.tplus = cur_f.t0;
      end else if (cur_f.t0) begin
         nxt_f.tplus = 1'b1;
         nxt_f.t1    = 1'b1;
      end else if (cur_f.t1) begin
         if (end_req) begin
            nxt_f.t0 = 1'b1;
         end else begin
            nxt_s[0] = 1'b1;
            nxt_f.t0 = two_cyc;
         end
      end else if (br_bypass && in_byp_window) begin
         nxt_f.t1 = 1'b1;
      end else if (end_req) begin
         nxt_f.t0 = 1'b1;
      end else begin
         nxt_s = shifted;
      end
   end
endmodule

// File: rtl/tcg_regs.sv
module tcg_regs
   import tcg_pkg::*;
#(
   parameter int N_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  tcg_flags_t        nxt_f,
   input  logic [N_STEP-1:0] nxt_s,
   output tcg_flags_t        cur_f,
   output logic [N_STEP-1:0] cur_s
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_f <= TCG_FLAGS_RESET;
         cur_s <= '0;
      end else begin
         cur_f <= nxt_f;
         cur_s <= nxt_s;
      end
   end
endmodule

// File: rtl/tcg_timing_gen.sv
module tcg_timing_gen
   import tcg_pkg::*;
#(
   parameter int N_STEP = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              two_cyc,
   input  logic              end_req,
   input  logic              br_bypass,
   input  logic              rst_sense,
   output logic              t0_n,
   output logic              tplus_n,
   output logic [N_STEP-1:0] tstep_n,
   output logic              t1,
   output logic              sync
);
   if (N_STEP < 2) begin : g_bad_param
      $error("tcg_timing_gen: N_STEP must be at least 2 so that T3 exists");
   end

   tcg_flags_t        cur_f, nxt_f;
   logic [N_STEP-1:0] cur_s, nxt_s;

   tcg_next #(.N_STEP(N_STEP)) i_next (
      .cur_f    (cur_f),
      .cur_s    (cur_s),
      .two_cyc  (two_cyc),
      .end_req  (end_req),
      .br_bypass(br_bypass),
      .rst_sense(rst_sense),
      .nxt_f    (nxt_f),
      .nxt_s    (nxt_s)
   );

   tcg_regs #(.N_STEP(N_STEP)) i_regs (
      .clk  (clk),
      .rst_n(rst_n),
      .nxt_f(nxt_f),
      .nxt_s(nxt_s),
      .cur_f(cur_f),
      .cur_s(cur_s)
   );

   assign t0_n    = ~cur_f.t0;
   assign tplus_n = ~cur_f.tplus;
   assign tstep_n = ~cur_s;
   assign t1      = cur_f.t1;
   assign sync    = cur_f.t1;

   AST_STEP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_sense && !end_req && !br_bypass && !cur_f.t0 && !cur_f.t1)
      |=> (cur_s == ($past(cur_s) << 1)));  // R1
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!rst_sense && !end_req && cur_s == '0 && cur_f == '0)
      |=> (cur_s == '0 && cur_f == '0));  // R1
   AST_REQ_T0: assert property (@(posedge clk) disable iff (!rst_n)
      (end_req && !rst_sense && !br_bypass && !cur_f.t0)
      |=> (cur_f.t0 && !cur_f.tplus && cur_s == '0));  // R2
   AST_T0_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_f.t0 && !rst_sense) |=> (cur_f.tplus && cur_f.t1 && cur_s == '0));  // R3
   AST_TWO_CYC: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_f.t1 && two_cyc && !end_req && !rst_sense)
      |=> (cur_f.t0 && cur_s[0]));  // R4
   AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
      (br_bypass && (cur_s[0] || cur_s[1]) && !cur_f.t0 && !cur_f.t1 && !rst_sense)
      |=> (cur_f.t1 && !cur_f.tplus));  // R5
   AST_TPLUS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      cur_f.tplus |-> $past(cur_f.t0));  // R5
   AST_RST_T0: assert property (@(posedge clk) disable iff (!rst_n)
      rst_sense |=> (cur_f.t0 && !cur_f.t1 && cur_s == '0));  // R6
   AST_RST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rst_sense && cur_f.t0) |=> (cur_f.t0 && cur_f.tplus));  // R7
   AST_T1_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_f.t1 && end_req && !rst_sense)
      |=> (cur_f.t0 && !cur_f.t1 && cur_s == '0));  // R8
   AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(cur_s));  // R1
endmodule

// File: tb/test_tcg_timing_gen.sv
module test_tcg_timing_gen;
   localparam int NS = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic two_cyc = 1'b0, end_req = 1'b0, br_bypass = 1'b0, rst_sense = 1'b0;
   logic t0_n, tplus_n, t1, sync;
   logic [NS-1:0] tstep_n;

   int tests = 0, fails = 0, cycles = 0;
   string cur = "R10";

   // Reference model: mstep is the cycle number 2..NS+1, or 0 when no step code
   bit mt0 = 1, mtp = 0, mt1 = 0;
   int mstep = 0;

   tcg_timing_gen #(.N_STEP(NS)) i_tcg_timing_gen (
      .clk(clk), .rst_n(rst_n), .two_cyc(two_cyc), .end_req(end_req),
      .br_bypass(br_bypass), .rst_sense(rst_sense), .t0_n(t0_n),
      .tplus_n(tplus_n), .tstep_n(tstep_n), .t1(t1), .sync(sync));

   always #5 clk = ~clk;

   always @(posedge clk or negedge rst_n) begin
      bit a0, ap, a1;
      int as;
      if (!rst_n) begin
         mt0 = 1; mtp = 0; mt1 = 0; mstep = 0;
      end else begin
         a0 = 0; ap = 0; a1 = 0; as = 0;
         if (rst_sense) begin a0 = 1; ap = mt0; end
         else if (mt0) begin ap = 1; a1 = 1; end
         else if (mt1) begin
            if (end_req) a0 = 1;
            else begin as = 2; a0 = two_cyc; end
         end
         else if (br_bypass && (mstep == 2 || mstep == 3)) a1 = 1;
         else if (end_req) a0 = 1;
         else if (mstep >= 2 && mstep < NS + 1) as = mstep + 1;
         mt0 = a0; mtp = ap; mt1 = a1; mstep = as;
      end
   end

   always @(negedge clk) begin
      logic [NS-1:0] es;
      if (rst_n) begin
         for (int i = 0; i < NS; i++) es[i] = !(mstep == i + 2);
         tests++;
         if (t0_n !== !mt0 || tplus_n !== !mtp || tstep_n !== es || t1 !== mt1) begin
            fails++;
            $display("FAIL %s: t0_n=%b tplus_n=%b tstep_n=%b t1=%b expected %b %b %b %b",
                     cur, t0_n, tplus_n, tstep_n, t1, !mt0, !mtp, es, mt1);
         end
         tests++;
         if (sync !== mt1) begin
            fails++;
            $display("FAIL R9: sync=%b expected %b", sync, mt1);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000) begin
         fails++;
         $display("FAIL watchdog: cycles=%0d expected below 20000", cycles);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic cyc(int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Entered during a T1 cycle; runs an n-cycle instruction back into T1
   task automatic instr(int n);
      cyc(1);
      cyc(n - 3);
      end_req = 1'b1; cyc(1); end_req = 1'b0;
      cyc(1);
   endtask

   initial begin
      cyc(2);
      rst_n = 1'b1;
      cyc(1);                         // R10: first cycle is T0 alone
      cur = "R3"; cyc(1);             // T+ with T1
      cur = "R2"; instr(3); instr(4); instr(5);
      cur = "R1"; instr(6);
      cur = "R4"; two_cyc = 1'b1; cyc(1); two_cyc = 1'b0; cyc(1);
      cur = "R5"; cyc(1); br_bypass = 1'b1; cyc(1); br_bypass = 1'b0;  // bypass at T2
      cyc(2); br_bypass = 1'b1; cyc(1); br_bypass = 1'b0;              // bypass at T3
      cur = "R8"; end_req = 1'b1; cyc(1); end_req = 1'b0; cyc(3);
      cur = "R1"; cyc(8);             // idle state persists
      cur = "R2"; end_req = 1'b1; cyc(1); end_req = 1'b0; cyc(1);
      cur = "R6"; cyc(2); rst_sense = 1'b1; cyc(1); rst_sense = 1'b0; cyc(3);
      cur = "R7"; cyc(1); rst_sense = 1'b1; cyc(5); rst_sense = 1'b0; cyc(3);
      cur = "R10"; end_req = 1'b1; rst_sense = 1'b1; cyc(1);
      end_req = 1'b0; rst_sense = 1'b0; cyc(3);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule